// File: doc/BRIEF.md
# Queue Ticket and Length Controller

This block is the control core of a single-counter queueing machine. A customer presses a join button; the block hands out the next ticket number and increases the queue length. A clerk presses a done button when a customer has been served; the block decreases the queue length. Both numbers are kept as packed BCD, four bits per decimal digit, with the most significant digit in the highest nibble. They can therefore feed a digit display with no conversion. With the default of two digits, the length is capped at 99. A join request against a full queue raises an overflow alarm instead of counting.

The two request inputs are level signals, such as debounced buttons. The block reacts only to a rising edge, so holding a button down counts once. A request register is cleared by reset. Because of this, a level that is already high when reset is released counts as one event on the first clock edge. The length is tracked by a four-state machine:

- `ST_EMPTY`: the length is 0.
- `ST_PARTIAL`: the length is between 1 and 98.
- `ST_FULL`: the length is 99 and the alarm is off.
- `ST_OVERFLOW`: the length is 99 and the alarm is on.

Each transition has a name:

| Transition | From | To | Cause |
|---|---|---|---|
| JOIN_FIRST | `ST_EMPTY` | `ST_PARTIAL` | a join |
| JOIN | `ST_PARTIAL` | `ST_PARTIAL` | a join |
| FILL | `ST_PARTIAL` | `ST_FULL` | a join at 98 |
| LEAVE | `ST_PARTIAL` | `ST_PARTIAL` | a done |
| DRAIN_LAST | `ST_PARTIAL` | `ST_EMPTY` | a done at 1 |
| REJECT | `ST_FULL` or `ST_OVERFLOW` | `ST_OVERFLOW` | a join when full |
| RELEASE | `ST_FULL` or `ST_OVERFLOW` | `ST_PARTIAL` | a done when full |
| SWAP | any non-empty state | same state | a join and a done together |
| IGNORE | `ST_EMPTY` | `ST_EMPTY` | a done with the queue empty |

Top module: `queue_ticket_ctrl`

## Requirements
- R1: While `rst_n` is low (asynchronously), `length_bcd` is 8'h00, `ticket_bcd` is 8'h00 and `overflow_alarm` is 0.
- R2: A rising edge of `join_req` below full raises `length_bcd` by one and advances `ticket_bcd`. The first ticket after reset is 8'h01. The new values appear after the first clock edge that samples the level high. A level held high for several cycles counts once.
- R3: A rising edge of `done_req` with a non-zero length, and without a join edge in the same cycle, lowers `length_bcd` by one.
- R4: Both outputs are packed BCD, with the tens digit in bits [7:4] and the units digit in bits [3:0]. Every nibble stays in the range 0 to 9. Incrementing carries 8'h09 to 8'h10, and decrementing borrows 8'h10 to 8'h09.
- R5: A join edge alone when the length is 8'h99 sets `overflow_alarm` and leaves the length and the ticket unchanged.
- R6: `overflow_alarm` is only ever high while the length is 8'h99. It stays set through further joins and through same-cycle join/done pairs. It clears on a lone done edge, which lowers the length to 8'h98, or on reset.
- R7: A done edge alone when the length is 8'h00 changes nothing.
- R8: A join edge and a done edge in the same cycle leave the length unchanged and advance the ticket. At length 8'h00, the done is ignored and the join counts normally.
- R9: The ticket after 8'h99 is 8'h01.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slow system clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| join_req | input | 1 | Join button level; its rising edge is one join |
| done_req | input | 1 | Service-complete button level; its rising edge is one completion |
| ticket_bcd | output | 8 | Last issued ticket, packed BCD |
| length_bcd | output | 8 | Current queue length, packed BCD |
| overflow_alarm | output | 1 | Set by a join against a full queue |

## Verification
A join and a service completion can land in the same clock cycle. The bench provokes this by raising both button levels on the same falling clock edge. It does so in three places: with the queue empty, part-full, and full with the alarm already set. A behavioural reference model predicts the outcome of each case. When the queue is not empty, the length must hold while the ticket advances. When the queue is empty, the completion is dropped and the join counts normally. When the queue is full, the alarm must survive the pair. The DUT's outputs are compared against the model on every cycle.

// File: rtl/qtc_pkg.sv
package qtc_pkg;

    localparam int unsigned QTC_DIGITS = 2;

    typedef enum logic [1:0] {
        ST_EMPTY    = 2'd0,
        ST_PARTIAL  = 2'd1,
        ST_FULL     = 2'd2,
        ST_OVERFLOW = 2'd3
    } qtc_state_e;

endpackage

// File: rtl/qtc_rise.sv
module qtc_rise (
    input  logic clk,
    input  logic rst_n,
    input  logic level_i,
    output logic event_o
);
    logic level_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            level_q <= 1'b0;
        end else begin
            level_q <= level_i;
        end
    end

    assign event_o = level_i & ~level_q;
endmodule

// File: rtl/qtc_bcd_cnt.sv
module qtc_bcd_cnt #(
    parameter int unsigned DIGITS  = 2,
    parameter bit          WRAP_ON = 1'b0,
    localparam int unsigned W      = 4 * DIGITS
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc_i,
    input  logic         dec_i,
    output logic [W-1:0] value_o,
    output logic         is_zero_o,
    output logic         is_one_o,
    output logic         is_max_o,
    output logic         is_premax_o
);
    localparam logic [W-1:0] ALL_NINE = {DIGITS{4'h9}};
    localparam logic [W-1:0] PRE_MAX  = ALL_NINE - W'(1);
    localparam logic [W-1:0] ONE      = W'(1);

    logic [W-1:0]  cnt_q;
    logic [W-1:0]  up_v;
    logic [W-1:0]  down_v;
    logic [W-1:0]  cnt_d;
    logic [DIGITS:0] carry;
    logic [DIGITS:0] borrow;

    assign carry[0]  = 1'b1;
    assign borrow[0] = 1'b1;

    for (genvar g = 0; g < DIGITS; g++) begin : g_digit
        logic [3:0] d;
        assign d = cnt_q[4*g +: 4];
        assign carry[g+1]  = carry[g]  & (d == 4'd9);
        assign borrow[g+1] = borrow[g] & (d == 4'd0);
        assign up_v[4*g +: 4]   = carry[g]  ? ((d == 4'd9) ? 4'd0 : d + 4'd1) : d;
        assign down_v[4*g +: 4] = borrow[g] ? ((d == 4'd0) ? 4'd9 : d - 4'd1) : d;
    end

    assign is_zero_o   = (cnt_q == '0);
    assign is_one_o    = (cnt_q == ONE);
    assign is_max_o    = (cnt_q == ALL_NINE);
    assign is_premax_o = (cnt_q == PRE_MAX);

    always_comb begin
        cnt_d = cnt_q;
        if (inc_i && !dec_i) begin
            if (is_max_o) begin
                cnt_d = WRAP_ON ? ONE : cnt_q;
            end else begin
                cnt_d = up_v;
            end
        end else if (dec_i && !inc_i) begin
            if (!is_zero_o) begin
                cnt_d = down_v;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign value_o = cnt_q;
endmodule

// File: rtl/qtc_fsm.sv
module qtc_fsm
    import qtc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic join_ev_i,
    input  logic done_ev_i,
    input  logic len_one_i,
    input  logic len_premax_i,
    output logic len_inc_o,
    output logic len_dec_o,
    output logic tkt_inc_o,
    output logic alarm_o
);
    qtc_state_e state_q;
    qtc_state_e state_d;
    logic       only_join;
    logic       only_done;
    logic       both;

    assign only_join = join_ev_i & ~done_ev_i;
    assign only_done = done_ev_i & ~join_ev_i;
    assign both      = join_ev_i & done_ev_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_EMPTY;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d   = state_q;
        len_inc_o = 1'b0;
        len_dec_o = 1'b0;
        tkt_inc_o = 1'b0;
        unique case (state_q)
            ST_EMPTY: begin
                if (join_ev_i) begin
                    len_inc_o = 1'b1;
                    tkt_inc_o = 1'b1;
                    state_d   = len_premax_i ? ST_FULL : ST_PARTIAL;
                end
            end
            ST_PARTIAL: begin
                if (only_join) begin
                    len_inc_o = 1'b1;
                    tkt_inc_o = 1'b1;
                    state_d   = len_premax_i ? ST_FULL : ST_PARTIAL;
                end else if (only_done) begin
                    len_dec_o = 1'b1;
                    state_d   = len_one_i ? ST_EMPTY : ST_PARTIAL;
                end else if (both) begin
                    tkt_inc_o = 1'b1;
                end
            end
            ST_FULL, ST_OVERFLOW: begin
                if (only_join) begin
                    state_d = ST_OVERFLOW;
                end else if (only_done) begin
                    len_dec_o = 1'b1;
                    state_d   = len_one_i ? ST_EMPTY : ST_PARTIAL;
                end else if (both) begin
                    tkt_inc_o = 1'b1;
                end
            end
            default: begin
                state_d = ST_EMPTY;
            end
        endcase
    end

    assign alarm_o = (state_q == ST_OVERFLOW);
endmodule

// File: rtl/queue_ticket_ctrl.sv
module queue_ticket_ctrl
    import qtc_pkg::*;
#(
    parameter int unsigned DIGITS = QTC_DIGITS,
    localparam int unsigned W     = 4 * DIGITS
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         join_req,
    input  logic         done_req,
    output logic [W-1:0] ticket_bcd,
    output logic [W-1:0] length_bcd,
    output logic         overflow_alarm
);
    logic join_ev;
    logic done_ev;
    logic len_inc;
    logic len_dec;
    logic tkt_inc;
    logic len_zero;
    logic len_one;
    logic len_max;
    logic len_premax;
    logic tkt_zero;
    logic tkt_one;
    logic tkt_max;
    logic tkt_premax;

    qtc_rise u_join_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .level_i (join_req),
        .event_o (join_ev)
    );

    qtc_rise u_done_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .level_i (done_req),
        .event_o (done_ev)
    );

    qtc_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .join_ev_i    (join_ev),
        .done_ev_i    (done_ev),
        .len_one_i    (len_one),
        .len_premax_i (len_premax),
        .len_inc_o    (len_inc),
        .len_dec_o    (len_dec),
        .tkt_inc_o    (tkt_inc),
        .alarm_o      (overflow_alarm)
    );

    qtc_bcd_cnt #(
        .DIGITS  (DIGITS),
        .WRAP_ON (1'b0)
    ) u_length (
        .clk         (clk),
        .rst_n       (rst_n),
        .inc_i       (len_inc),
        .dec_i       (len_dec),
        .value_o     (length_bcd),
        .is_zero_o   (len_zero),
        .is_one_o    (len_one),
        .is_max_o    (len_max),
        .is_premax_o (len_premax)
    );

    qtc_bcd_cnt #(
        .DIGITS  (DIGITS),
        .WRAP_ON (1'b1)
    ) u_ticket (
        .clk         (clk),
        .rst_n       (rst_n),
        .inc_i       (tkt_inc),
        .dec_i       (1'b0),
        .value_o     (ticket_bcd),
        .is_zero_o   (tkt_zero),
        .is_one_o    (tkt_one),
        .is_max_o    (tkt_max),
        .is_premax_o (tkt_premax)
    );

    logic unused_flags;
    assign unused_flags = len_zero ^ len_max ^ tkt_zero ^ tkt_one ^ tkt_max ^ tkt_premax;
endmodule

// File: rtl/qtc_checker.sv
module qtc_checker #(
    parameter int unsigned W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         join_req,
    input logic         done_req,
    input logic [W-1:0] ticket_bcd,
    input logic [W-1:0] length_bcd,
    input logic         overflow_alarm
);
    localparam logic [W-1:0] NINES = {(W/4){4'h9}};
    localparam logic [W-1:0] ONE   = W'(1);

    logic jq;
    logic dq;
    logic jev;
    logic dev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            jq <= 1'b0;
            dq <= 1'b0;
        end else begin
            jq <= join_req;
            dq <= done_req;
        end
    end

    assign jev = join_req & ~jq;
    assign dev = done_req & ~dq;

    function automatic bit digits_ok(input logic [W-1:0] v);
        bit ok;
        ok = 1'b1;
        for (int i = 0; i < W / 4; i++) begin
            if (v[4*i +: 4] > 4'd9) ok = 1'b0;
        end
        return ok;
    endfunction

    AST_ALARM_AT_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        overflow_alarm |-> (length_bcd == NINES)); // R6

    AST_BCD_DIGITS: assert property (@(posedge clk) disable iff (!rst_n)
        digits_ok(length_bcd) && digits_ok(ticket_bcd)); // R4

    AST_REJECT_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        (length_bcd == NINES && jev && !dev) |=>
        (overflow_alarm && $stable(length_bcd) && $stable(ticket_bcd))); // R5

    AST_EMPTY_IGNORE: assert property (@(posedge clk) disable iff (!rst_n)
        (length_bcd == '0 && dev && !jev) |=>
        (length_bcd == '0 && $stable(ticket_bcd))); // R7

    AST_SWAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (length_bcd != '0 && jev && dev) |=> $stable(length_bcd)); // R8

    AST_TICKET_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (ticket_bcd == NINES && jev && length_bcd != NINES) |=> (ticket_bcd == ONE)); // R9

    AST_ALARM_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (overflow_alarm && dev && !jev) |=> !overflow_alarm); // R6

    AST_DONE_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (length_bcd != '0 && dev && !jev) |=> (length_bcd != $past(length_bcd))); // R3
endmodule

bind queue_ticket_ctrl qtc_checker #(.W(W)) chk_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .join_req       (join_req),
    .done_req       (done_req),
    .ticket_bcd     (ticket_bcd),
    .length_bcd     (length_bcd),
    .overflow_alarm (overflow_alarm)
);

// File: tb/queue_ticket_ctrl_tb_top.sv
module queue_ticket_ctrl_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       join_req = 1'b0;
    logic       done_req = 1'b0;
    logic [7:0] ticket_bcd;
    logic [7:0] length_bcd;
    logic       overflow_alarm;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    int    mlen = 0;
    int    mtkt = 0;
    int    malarm = 0;
    bit    pj = 0;
    bit    pd = 0;
    bit    je;
    bit    de;
    string mtag = "R1";

    always #4 clk = ~clk;

    queue_ticket_ctrl dut_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .join_req       (join_req),
        .done_req       (done_req),
        .ticket_bcd     (ticket_bcd),
        .length_bcd     (length_bcd),
        .overflow_alarm (overflow_alarm)
    );

    function automatic logic [7:0] to_bcd(input int v);
        return {4'(v / 10), 4'(v % 10)};
    endfunction

    function automatic int next_tkt(input int t);
        return (t == 99) ? 1 : t + 1;
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Behavioural reference model
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mlen = 0; mtkt = 0; malarm = 0; pj = 0; pd = 0; mtag = "R1";
        end else begin
            je = join_req && !pj;
            de = done_req && !pd;
            pj = join_req;
            pd = done_req;
            if (je && de) begin
                mtkt = next_tkt(mtkt);
                if (mlen == 0) mlen = 1;
                mtag = "R8";
            end else if (je) begin
                if (mlen == 99) begin
                    malarm = 1; mtag = "R5";
                end else begin
                    mtag = (mtkt == 99) ? "R9" : "R2";
                    mlen = mlen + 1; mtkt = next_tkt(mtkt);
                end
            end else if (de) begin
                if (mlen == 0) begin
                    mtag = "R7";
                end else begin
                    mtag = malarm ? "R6" : "R3";
                    mlen = mlen - 1; malarm = 0;
                end
            end else begin
                mtag = "R4";
            end
        end
    end

    // Per-cycle comparison away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            check({mtag, " length"}, length_bcd, to_bcd(mlen));
            check({mtag, " ticket"}, ticket_bcd, to_bcd(mtkt));
            check({mtag, " alarm"}, overflow_alarm, malarm);
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            fails++; checks++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    task automatic press(input bit j, input bit d, input int hold);
        @(negedge clk);
        join_req = j; done_req = d;
        repeat (hold) @(negedge clk);
        join_req = 0; done_req = 0;
    endtask

    initial begin
        #1;
        check("R1 length in reset", length_bcd, 0);
        check("R1 ticket in reset", ticket_bcd, 0);
        check("R1 alarm in reset", overflow_alarm, 0);
        repeat (2) @(negedge clk);
        rst_n = 1;

        press(1, 0, 1);
        #1 check("R2 first ticket", ticket_bcd, 8'h01);
        check("R2 length one", length_bcd, 8'h01);

        press(1, 0, 4);
        #1 check("R2 held level counts once", length_bcd, 8'h02);

        for (int i = 0; i < 8; i++) press(1, 0, 1);
        #1 check("R4 carry to tens", length_bcd, 8'h10);

        press(0, 1, 1);
        #1 check("R4 borrow from tens", length_bcd, 8'h09);
        check("R3 ticket kept on done", ticket_bcd, 8'h10);

        press(1, 1, 1);
        #1 check("R8 length held on pair", length_bcd, 8'h09);
        check("R8 ticket advanced on pair", ticket_bcd, 8'h11);

        while (mlen > 0) press(0, 1, 1);
        press(0, 1, 1);
        #1 check("R7 done at empty ignored", length_bcd, 8'h00);
        check("R7 ticket unchanged", ticket_bcd, 8'h11);

        press(1, 1, 1);
        #1 check("R8 pair at empty joins", length_bcd, 8'h01);

        while (mlen < 99) press(1, 0, 1);
        #1 check("R9 ticket wrapped", ticket_bcd, to_bcd(mtkt));
        check("R6 no alarm at plain full", overflow_alarm, 0);

        press(1, 0, 1);
        #1 check("R5 alarm set", overflow_alarm, 1);
        check("R5 length frozen", length_bcd, 8'h99);

        press(1, 1, 1);
        #1 check("R6 alarm kept through pair", overflow_alarm, 1);
        check("R8 length held at full", length_bcd, 8'h99);

        press(0, 1, 1);
        #1 check("R6 alarm cleared by done", overflow_alarm, 0);
        check("R3 length to 98", length_bcd, 8'h98);

        press(1, 0, 1);
        press(1, 0, 1);
        #1 check("R5 alarm again", overflow_alarm, 1);

        @(negedge clk);
        #2 rst_n = 0;
        #1 check("R1 async reset length", length_bcd, 0);
        check("R1 async reset alarm", overflow_alarm, 0);
        check("R1 async reset ticket", ticket_bcd, 0);
        @(negedge clk);
        rst_n = 1;
        press(1, 0, 1);
        #1 check("R2 first ticket after reset", ticket_bcd, 8'h01);

        repeat (3) @(negedge clk);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule